// File: doc/BRIEF.md
# Memory-Mapped Level Interrupt Controller

This block collects up to 32 interrupt sources into one processor interrupt line and gives software a small register window to inspect and gate them. Each source owns one bit position in a cause word and the same position in a mask word. The processor line is raised whenever any source is both pending and enabled. Software finds out which source fired by reading the cause word and scanning it. The block does no prioritisation or vectoring.

Nearly every cause bit is a live copy of its source line, so it clears by itself when the line drops. The reset-switch source is the exception. The active-low switch input passes through a synchronizer. A press, seen as a falling edge of the synchronized level, sets a sticky latch. Only a write-1-to-clear access removes that latch. The same cause word carries a read-only copy of the live switch level. A byte write of zero to a third register sends a one-cycle platform-reset request.

Writes take one cycle and honour per-byte enables. Reads are combinational from the read address.

Top module: `lvlirq_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the mask word is 0, the sticky switch latch is 0 and `plat_rst_o` is 0. With all source lines low and the switch released, the cause word reads 0x0001_0000.
- R2: Every cause bit other than bit 1 and bit 16 equals its `src_lvl` line combinationally. Writes to the cause register leave these bits unchanged.
- R3: Cause bit 16 reads the switch level after a 2-flop synchronizer: 1 when released, 0 when pressed. It is read-only. When `sw_n` changes just after a clock edge, the new level shows after the second following edge.
- R4: Cause bit 1 is a sticky latch. It is set by the clock edge after the synchronized level falls, which is the third edge after `sw_n` falls. It stays set after the switch is released.
- R5: A write to the cause register (offset 0x00) with `wr_be[0]`=1 and `wr_data[1]`=1 clears the latch. Writing 0 there, or writing with lane 0 disabled, has no effect. If a press edge and a clearing write arrive on the same edge, the latch stays set.
- R6: The mask register is at offset 0x04, and a mask bit set to 1 enables its source. Byte lane k (`wr_be[k]`) writes mask bits 8k+7..8k. Lanes that are not enabled keep their value. Writes to other offsets leave the mask unchanged.
- R7: `irq_o` is 1 exactly when the bitwise AND of the cause word and the mask word is nonzero. It follows combinationally from the lines and from the state held in the registers.
- R8: A write to offset 0x24 with `wr_be[0]`=1 and `wr_data[7:0]`=0x00 drives `plat_rst_o` high for exactly the one cycle after the write edge. Any other byte value, or lane 0 disabled, gives no pulse. This register changes neither the mask nor the latch.
- R9: `rd_data` shows the cause word at 0x00 and the mask word at 0x04. It reads 0 at 0x24 and at any unmapped offset.
- R10: Writing 0 to the mask and then all ones to the cause register leaves every source disabled, `irq_o` low and the latch cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 32 | Level source lines; bits 1 and 16 are ignored |
| sw_n | input | 1 | Reset switch, active low, asynchronous |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write byte offset |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Write byte enables, bit k covers data bits 8k+7..8k |
| rd_addr | input | 6 | Read byte offset |
| rd_data | output | 32 | Read data, combinational |
| irq_o | output | 1 | Processor interrupt request |
| plat_rst_o | output | 1 | One-cycle platform reset request |

## Verification
The hardest case to reach from the ports is a switch press edge that lands on the same clock edge as a software write clearing the latch. The latch must stay set in that case. To get there, the stimulus first sets and releases the latch. It then lowers `sw_n` on a falling clock edge, waits exactly two clock edges for the synchronizer to carry the level through, and issues the clearing write so that it is captured on the third edge, the edge on which the press is registered. The bench also sweeps every bit position through the level-follow path and the mask/interrupt path, and compares against an expected cause word it builds from the line pattern and its own model of the latch and the switch.

// File: rtl/lvlirq_pkg.sv
package lvlirq_pkg;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_CAUSE,
      SEL_MASK,
      SEL_PRST
   } reg_sel_e;

   function automatic reg_sel_e decode_sel(input logic [31:0] addr,
                                           input int unsigned cause_off,
                                           input int unsigned mask_off,
                                           input int unsigned prst_off);
      if (addr == cause_off)      return SEL_CAUSE;
      else if (addr == mask_off)  return SEL_MASK;
      else if (addr == prst_off)  return SEL_PRST;
      else                        return SEL_NONE;
   endfunction

endpackage

// File: rtl/lvlirq_sw_sync.sv
module lvlirq_sw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sw_n,
   output logic sw_live,
   output logic press
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lvlirq_sw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], sw_n};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign sw_live = chain_q[STAGES-1];
   assign press   = prev_q & ~chain_q[STAGES-1];

   // R4
   press_single_chk: assert property (@(posedge clk) disable iff (rst)
      press |=> !press);

endmodule

// File: rtl/lvlirq_cause.sv
module lvlirq_cause #(
   parameter int NSRC      = 32,
   parameter int LATCH_BIT = 1,
   parameter int STATE_BIT = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] src_lvl,
   input  logic            sw_live,
   input  logic            press,
   input  logic            clr_latch,
   output logic [NSRC-1:0] cause
);

   generate
      if (LATCH_BIT >= NSRC || STATE_BIT >= NSRC || LATCH_BIT == STATE_BIT) begin : g_bad_bits
         $error("lvlirq_cause: special bit positions invalid");
      end
      for (genvar i = 0; i < NSRC; i++) begin : g_bit
         if (i == LATCH_BIT) begin : g_latch
            logic latch_q;
            logic unused_src;
            assign unused_src = src_lvl[i];
            always_ff @(posedge clk) begin
               if (rst)            latch_q <= 1'b0;
               else if (press)     latch_q <= 1'b1;
               else if (clr_latch) latch_q <= 1'b0;
            end
            assign cause[i] = latch_q;

            // R4
            latch_set_src_chk: assert property (@(posedge clk) disable iff (rst)
               $rose(latch_q) |-> $past(press));
            // R5
            latch_clr_src_chk: assert property (@(posedge clk) disable iff (rst)
               $fell(latch_q) |-> ($past(clr_latch) && !$past(press)));
         end else if (i == STATE_BIT) begin : g_state
            logic unused_src;
            assign unused_src = src_lvl[i];
            assign cause[i]   = sw_live;
         end else begin : g_level
            assign cause[i] = src_lvl[i];
         end
      end
   endgenerate

endmodule

// File: rtl/lvlirq_mask.sv
module lvlirq_mask #(
   parameter  int NSRC  = 32,
   localparam int NLANE = NSRC / 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [NSRC-1:0]  wdata,
   input  logic [NLANE-1:0] be,
   output logic [NSRC-1:0]  mask
);

   generate
      if (NSRC % 8 != 0 || NSRC < 8) begin : g_bad_width
         $error("lvlirq_mask: NSRC must be a nonzero multiple of 8");
      end
      for (genvar l = 0; l < NLANE; l++) begin : g_lane
         logic [7:0] lane_q;
         always_ff @(posedge clk) begin
            if (rst)               lane_q <= '0;
            else if (we && be[l])  lane_q <= wdata[8*l +: 8];
         end
         assign mask[8*l +: 8] = lane_q;
      end
   endgenerate

   // R6
   mask_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!we || be == '0) |=> $stable(mask));

endmodule

// File: rtl/lvlirq_ctrl.sv
module lvlirq_ctrl #(
   parameter int          NSRC        = 32,
   parameter int          AW          = 6,
   parameter int          LATCH_BIT   = 1,
   parameter int          STATE_BIT   = 16,
   parameter int          SYNC_STAGES = 2,
   parameter int unsigned CAUSE_OFF   = 'h00,
   parameter int unsigned MASK_OFF    = 'h04,
   parameter int unsigned PRST_OFF    = 'h24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NSRC-1:0]   src_lvl,
   input  logic              sw_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [NSRC-1:0]   wr_data,
   input  logic [NSRC/8-1:0] wr_be,
   input  logic [AW-1:0]     rd_addr,
   output logic [NSRC-1:0]   rd_data,
   output logic              irq_o,
   output logic              plat_rst_o
);
   import lvlirq_pkg::*;

   localparam int NLANE      = NSRC / 8;
   localparam int LATCH_LANE = LATCH_BIT / 8;

   generate
      if (AW > 32 || PRST_OFF >= (64'd1 << AW) || MASK_OFF >= (64'd1 << AW)
          || CAUSE_OFF >= (64'd1 << AW)) begin : g_bad_addr
         $error("lvlirq_ctrl: offsets do not fit the address width");
      end
      if (CAUSE_OFF == MASK_OFF || CAUSE_OFF == PRST_OFF || MASK_OFF == PRST_OFF) begin : g_bad_map
         $error("lvlirq_ctrl: register offsets must be distinct");
      end
   endgenerate

   reg_sel_e        wr_sel, rd_sel;
   logic [NSRC-1:0] cause, mask_q;
   logic            sw_live, press, clr_latch, mask_we, prst_hit, prst_q;

   assign wr_sel = wr_en ? decode_sel(32'(wr_addr), CAUSE_OFF, MASK_OFF, PRST_OFF) : SEL_NONE;
   assign rd_sel = decode_sel(32'(rd_addr), CAUSE_OFF, MASK_OFF, PRST_OFF);

   assign clr_latch = (wr_sel == SEL_CAUSE) && wr_be[LATCH_LANE] && wr_data[LATCH_BIT];
   assign mask_we   = (wr_sel == SEL_MASK);
   assign prst_hit  = (wr_sel == SEL_PRST) && wr_be[0] && (wr_data[7:0] == 8'h00);

   lvlirq_sw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .sw_n    (sw_n),
      .sw_live (sw_live),
      .press   (press)
   );

   lvlirq_cause #(.NSRC(NSRC), .LATCH_BIT(LATCH_BIT), .STATE_BIT(STATE_BIT)) u_cause (
      .clk       (clk),
      .rst       (rst),
      .src_lvl   (src_lvl),
      .sw_live   (sw_live),
      .press     (press),
      .clr_latch (clr_latch),
      .cause     (cause)
   );

   lvlirq_mask #(.NSRC(NSRC)) u_mask (
      .clk   (clk),
      .rst   (rst),
      .we    (mask_we),
      .wdata (wr_data),
      .be    (wr_be[NLANE-1:0]),
      .mask  (mask_q)
   );

   always_ff @(posedge clk) begin
      if (rst) prst_q <= 1'b0;
      else     prst_q <= prst_hit;
   end
   assign plat_rst_o = prst_q;

   always_comb begin
      unique case (rd_sel)
         SEL_CAUSE: rd_data = cause;
         SEL_MASK:  rd_data = mask_q;
         default:   rd_data = '0;
      endcase
   end

   assign irq_o = |(cause & mask_q);

   // R7
   irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
      (mask_q == '0) |-> !irq_o);
   // R8
   prst_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
      plat_rst_o |-> $past(wr_en && wr_be[0]));
   // R8
   prst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> !plat_rst_o);
   // R6
   mask_other_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel != SEL_MASK) |=> $stable(mask_q));

endmodule

// File: tb/lvlirq_ctrl_test.sv
module lvlirq_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] A_CAUSE = 6'h00, A_MASK = 6'h04, A_PRST = 6'h24;
   localparam logic [31:0] B1 = 32'h0000_0002, B16 = 32'h0001_0000;

   logic        clk = 1'b0, rst = 1'b1, sw_n = 1'b1, wr_en = 1'b0;
   logic [31:0] src_lvl = '0, wr_data = '0, rd_data;
   logic [5:0]  wr_addr = '0, rd_addr = '0;
   logic [3:0]  wr_be = '0;
   logic        irq_o, plat_rst_o;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lvlirq_ctrl uut (
      .clk(clk), .rst(rst), .src_lvl(src_lvl), .sw_n(sw_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .plat_rst_o(plat_rst_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // caller is at a falling edge; write is captured on the next rising edge
   task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
      @(negedge clk);
      wr_en = 1'b0; wr_be = '0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // level part of the cause word: bits 1 and 16 replaced by the model
   function automatic logic [31:0] exp_cause(input logic [31:0] s, input bit latch, input bit sw_up);
      return (s & ~(B1 | B16)) | (latch ? B1 : 32'h0) | (sw_up ? B16 : 32'h0);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, pat, m;
      idle(3);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      rd(A_CAUSE, d); chk("R1 cause", d, B16);
      rd(A_MASK, d);  chk("R1 mask", d, 32'h0);
      chk("R1 irq", {31'h0, irq_o}, 32'h0);
      chk("R1 plat_rst", {31'h0, plat_rst_o}, 32'h0);

      // R2 level sweep over every ordinary bit
      for (int i = 0; i < 32; i++) begin
         if (i != 1 && i != 16) begin
            src_lvl = 32'(1) << i;
            rd(A_CAUSE, d); chk("R2 level follow", d, exp_cause(src_lvl, 0, 1));
         end
      end
      src_lvl = '0;
      rd(A_CAUSE, d); chk("R2 level drop", d, B16);

      // R2/R3 cause writes do not touch level bits or bit16
      pat = 32'hF0F0_0F0C;
      src_lvl = pat;
      @(negedge clk);
      wr(A_CAUSE, 32'hFFFF_FFFF, 4'hF);
      rd(A_CAUSE, d); chk("R2 write ignored", d, exp_cause(pat, 0, 1));
      wr(A_CAUSE, 32'h0000_0000, 4'hF);
      rd(A_CAUSE, d); chk("R2 write zero ignored", d, exp_cause(pat, 0, 1));

      // R6/R7 mask sweep against the pattern
      for (int i = 0; i < 32; i++) begin
         m = 32'(1) << i;
         wr(A_MASK, m, 4'hF);
         rd(A_MASK, d); chk("R6 mask walk", d, m);
         chk("R7 irq walk", {31'h0, irq_o}, {31'h0, |(exp_cause(pat, 0, 1) & m)});
      end

      // R6 byte lanes
      wr(A_MASK, 32'h0, 4'hF);
      wr(A_MASK, 32'hFFFF_FFFF, 4'b0100);
      rd(A_MASK, d); chk("R6 lane2 only", d, 32'h00FF_0000);
      wr(A_MASK, 32'h1234_5678, 4'b1001);
      rd(A_MASK, d); chk("R6 lanes 3 and 0", d, 32'h12FF_0078);
      wr(A_CAUSE, 32'hFFFF_FFFF, 4'hF);
      rd(A_MASK, d); chk("R6 other offset", d, 32'h12FF_0078);

      // R9 unmapped and reset-register reads
      rd(A_PRST, d); chk("R9 read 0x24", d, 32'h0);
      rd(6'h08, d);  chk("R9 read unmapped", d, 32'h0);

      // R3/R4 switch press
      src_lvl = '0;
      wr(A_MASK, B1, 4'hF);
      sw_n = 1'b0;
      idle(2);
      rd(A_CAUSE, d); chk("R3 live low after sync", d, 32'h0);
      chk("R4 not yet latched irq", {31'h0, irq_o}, 32'h0);
      idle(1);
      rd(A_CAUSE, d); chk("R4 latched", d, B1);
      chk("R7 irq from latch", {31'h0, irq_o}, 32'h1);
      wr(A_CAUSE, B16, 4'hF);
      rd(A_CAUSE, d); chk("R3 bit16 read-only", d, B1);
      sw_n = 1'b1;
      idle(1);
      rd(A_CAUSE, d); chk("R3 sync delay on release", d, B1);
      idle(2);
      rd(A_CAUSE, d); chk("R4 sticky after release", d, B1 | B16);

      // R5 clearing rules
      wr(A_CAUSE, 32'hFFFF_FFFD, 4'hF);
      rd(A_CAUSE, d); chk("R5 zero write keeps", d, B1 | B16);
      wr(A_CAUSE, B1, 4'b1110);
      rd(A_CAUSE, d); chk("R5 lane0 off keeps", d, B1 | B16);
      wr(A_CAUSE, B1, 4'b0001);
      rd(A_CAUSE, d); chk("R5 cleared", d, B16);
      chk("R5 irq low", {31'h0, irq_o}, 32'h0);

      // R5 press edge and clear on the same edge: set wins
      sw_n = 1'b0;
      idle(2);
      wr(A_CAUSE, B1, 4'hF);
      rd(A_CAUSE, d); chk("R5 set wins", d, B1);
      sw_n = 1'b1;
      idle(3);
      wr(A_CAUSE, B1, 4'h1);
      rd(A_CAUSE, d); chk("R5 cleared again", d, B16);

      // R8 platform reset pulse
      wr(A_MASK, 32'hA5A5_5A5A, 4'hF);
      wr(A_PRST, 32'hFFFF_FF00, 4'b0001);
      chk("R8 pulse high", {31'h0, plat_rst_o}, 32'h1);
      idle(1);
      chk("R8 pulse one cycle", {31'h0, plat_rst_o}, 32'h0);
      wr(A_PRST, 32'h0000_0001, 4'b0001);
      chk("R8 nonzero byte", {31'h0, plat_rst_o}, 32'h0);
      wr(A_PRST, 32'h0000_0000, 4'b0010);
      chk("R8 lane0 off", {31'h0, plat_rst_o}, 32'h0);
      rd(A_MASK, d); chk("R8 mask untouched", d, 32'hA5A5_5A5A);
      rd(A_CAUSE, d); chk("R8 cause untouched", d, B16);

      // R10 quiesce sequence
      sw_n = 1'b0; idle(3); sw_n = 1'b1; idle(3);
      pat = 32'h8001_0F01;
      src_lvl = pat;
      wr(A_MASK, 32'hFFFF_FFFF, 4'hF);
      chk("R10 irq before", {31'h0, irq_o}, 32'h1);
      wr(A_MASK, 32'h0, 4'hF);
      wr(A_CAUSE, 32'hFFFF_FFFF, 4'hF);
      rd(A_MASK, d);  chk("R10 mask zero", d, 32'h0);
      rd(A_CAUSE, d); chk("R10 latch cleared", d, exp_cause(pat, 0, 1));
      chk("R10 irq low", {31'h0, irq_o}, 32'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule